// File: doc/BRIEF.md
# System Control Register Bank

This block is the set of sixteen 32-bit system control registers that a processor core reaches through coprocessor transfers. Each transfer presents a primary register number, a secondary register number, two opcode fields, a data word, a read/write direction and the core's privilege level. In the cycle after the transfer, the bank does one of four things. It returns read data, updates a register, issues a one-cycle maintenance command for the caches or TLBs, or raises an undefined-instruction trap when the transfer is not legal.

The control register drives the memory-system configuration outputs continuously: MMU enable, alignment checking, cache enables, byte order, protection bits, replacement policy, exception vector base and clocking mode. Two read-only identity words share register 0 and are told apart by the second opcode. Registers 7 and 8 are write-only command ports. Register 8 turns the secondary register and second opcode into a one-hot TLB invalidate pulse.

Top module: `sysctl_regbank`

## Requirements
- R1: A transfer with `xfer_priv`=0 (user mode) raises `undef_trap` for one cycle. It changes no register and issues no command pulse.
- R2: A nonzero `xfer_op1` traps. For registers 1, 2, 3, 5, 6, 9, 10, 13 and 15, a nonzero `xfer_crm` or `xfer_op2` also traps.
- R3: A read of register 0 returns 0x0D172172 (cache type) when `xfer_op2`=1, and 0x41129200 (identity) for any other `xfer_op2`. A write to register 0, or a read with `xfer_crm`≠0, traps.
- R4: Register 1 stores only bits 0, 1, 2, 7, 8, 9, 12, 13, 14, 30 and 31 (mask 0xC0007387). On read, bits [6:3] return 1111 and all other bits return 0. After reset, register 1 reads 0x00000078.
- R5: The control outputs follow register 1: `mmu_en`=bit 0, `align_chk_en`=bit 1, `dcache_en`=bit 2, `big_endian`=bit 7, `sys_prot`=bit 8, `rom_prot`=bit 9, `icache_en`=bit 12, `rr_replace`=bit 14. `vec_base` is 0x00000000 when bit 13 is 0 and 0xFFFF0000 when it is 1.
- R6: `clk_mode` is 00 (fast bus) when bit 30 is 0. It is 01 (synchronous) when bit 30 is 1 and bit 31 is 0, and 10 (asynchronous) when both bits are 1. The value 11 never appears.
- R7: Register 2 keeps write bits [31:14] and reads bits [13:0] as zero. Register 3 keeps and returns all 32 bits.
- R8: Registers 5, 6, 9, 10, 13 and 15 are plain 32-bit read/write storage that resets to zero.
- R9: A write to register 8 pulses one bit of `tlb_cmd`, selected by ({crm},{op2}): (7,0) sets bit 0 (all), (5,0) bit 1 (instruction), (5,1) bit 2 (instruction entry), (6,0) bit 3 (data), (6,1) bit 4 (data entry). `maint_addr` takes the write data. Any other combination traps and pulses nothing.
- R10: A write to register 7 pulses `cache_cmd` for one cycle, sets `cache_sel`={crm[3:0],op2[2:0]} and loads `maint_addr` with the write data.
- R11: The following transfers trap: reads of registers 4, 7, 8, 11, 12 and 14, and writes to registers 4, 11, 12 and 14. Whenever `undef_trap` is high, `rd_data` is zero and `rd_valid` is low.
- R12: `rd_valid`, `rd_data`, `undef_trap`, `tlb_cmd` and `cache_cmd` respond exactly one cycle after the transfer and stay up for one cycle only. A register update shows on the control outputs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | Transfer present this cycle |
| xfer_write | input | 1 | 1 = write to bank, 0 = read from bank |
| xfer_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| xfer_crn | input | 4 | Primary register number |
| xfer_crm | input | 4 | Secondary register number |
| xfer_op1 | input | 3 | First opcode field |
| xfer_op2 | input | 3 | Second opcode field |
| xfer_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| undef_trap | output | 1 | Undefined-instruction trap pulse |
| tlb_cmd | output | 5 | One-hot TLB invalidate pulse |
| cache_cmd | output | 1 | Cache maintenance pulse |
| cache_sel | output | 7 | Cache operation selector {crm, op2} |
| maint_addr | output | 32 | Address for maintenance commands |
| mmu_en | output | 1 | MMU enable |
| align_chk_en | output | 1 | Alignment fault check enable |
| dcache_en | output | 1 | Data cache enable |
| icache_en | output | 1 | Instruction cache enable |
| big_endian | output | 1 | Big-endian byte order |
| sys_prot | output | 1 | System protection bit |
| rom_prot | output | 1 | ROM protection bit |
| rr_replace | output | 1 | Round-robin replacement select |
| vec_base | output | 32 | Exception vector base |
| clk_mode | output | 2 | Clocking mode |

## Verification
The bench targets the following corner cases:
- **Register 0 selection.** Every second-opcode value is read from register 0. A design that decoded only opcode 0 as the identity word would return the wrong word or trap.
- **Control register readback.** The control register is written with all ones and with all zeros. A design that stored reserved bits, or lost the fixed 1111 field, would show it in the readback and in `clk_mode`.
- **Privilege and illegal fields.** User-mode writes are followed by privileged readbacks. A design that let a trapped transfer update state would be caught there.
- **TLB command decoding.** Every register-8 combination is tried, along with near misses such as (7,1). The bench also checks the cycle after each pulse, which exposes a pulse that lingers or a decode that accepts a wrong pair.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_REG  = 16;
    localparam int unsigned RIDX_W   = $clog2(NUM_REG);
    localparam int unsigned CRM_W    = 4;
    localparam int unsigned OP_W     = 3;
    localparam int unsigned TLB_OPS  = 5;
    localparam int unsigned SEL_W    = CRM_W + OP_W;
    localparam int unsigned NUM_GP   = 6;
    localparam int unsigned GP_IW    = $clog2(NUM_GP);
    localparam int unsigned TTB_LSB  = 14;
    localparam int unsigned TTB_W    = DATA_W - TTB_LSB;

    localparam logic [DATA_W-1:0] CTRL_WMASK  = 32'hC000_7387;
    localparam logic [DATA_W-1:0] CTRL_FIXED1 = 32'h0000_0078;
    localparam logic [DATA_W-1:0] VEC_HIGH    = 32'hFFFF_0000;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_TRAP,
        ACT_READ,
        ACT_WRITE,
        ACT_TLB,
        ACT_CACHE
    } act_e;

    typedef struct packed {
        logic [DATA_W-1:0]             ctrl;
        logic [TTB_W-1:0]              ttb;
        logic [DATA_W-1:0]             dac;
        logic [NUM_GP-1:0][DATA_W-1:0] gp;
        logic [DATA_W-1:0]             rd_data;
        logic                          rd_valid;
        logic                          trap;
        logic [TLB_OPS-1:0]            tlb_cmd;
        logic                          cache_cmd;
        logic [SEL_W-1:0]              cache_sel;
        logic [DATA_W-1:0]             maint_addr;
    } bank_t;

    function automatic logic [DATA_W-1:0] ident_word();
        return {8'h41, 4'h1, 4'h2, 12'h920, 4'h0};
    endfunction

    function automatic logic [DATA_W-1:0] cache_word();
        return {3'b000, 4'b0110, 1'b1, 3'b000, 3'b101, 3'b110, 1'b0, 2'b10,
                3'b000, 3'b101, 3'b110, 1'b0, 2'b10};
    endfunction

    // {hit, slot} for the plain storage registers
    function automatic logic [GP_IW:0] gp_slot(input logic [RIDX_W-1:0] crn);
        case (crn)
            4'd5:    return {1'b1, 3'd0};
            4'd6:    return {1'b1, 3'd1};
            4'd9:    return {1'b1, 3'd2};
            4'd10:   return {1'b1, 3'd3};
            4'd13:   return {1'b1, 3'd4};
            4'd15:   return {1'b1, 3'd5};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic               valid,
    input  logic               write,
    input  logic               priv,
    input  logic [RIDX_W-1:0]  crn,
    input  logic [CRM_W-1:0]   crm,
    input  logic [OP_W-1:0]    op1,
    input  logic [OP_W-1:0]    op2,
    output act_e               act,
    output logic [TLB_OPS-1:0] tlb_sel
);

    localparam logic [SEL_W-1:0] TLB_CODE [0:TLB_OPS-1] =
        '{7'h38, 7'h28, 7'h29, 7'h30, 7'h31};

    logic [TLB_OPS-1:0] code_hit;
    logic               plain_ok;

    for (genvar i = 0; i < TLB_OPS; i++) begin : g_tlb
        assign code_hit[i] = ({crm, op2} == TLB_CODE[i]);
    end

    assign plain_ok = (crm == '0) && (op2 == '0);

    always_comb begin
        act     = ACT_TRAP;
        tlb_sel = '0;
        if (!valid) begin
            act = ACT_IDLE;
        end else if (priv && (op1 == '0)) begin
            case (crn)
                4'd0: begin
                    if (!write && (crm == '0)) act = ACT_READ;
                end
                4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd9, 4'd10, 4'd13, 4'd15: begin
                    if (plain_ok) act = write ? ACT_WRITE : ACT_READ;
                end
                4'd7: begin
                    if (write) act = ACT_CACHE;
                end
                4'd8: begin
                    if (write && (code_hit != '0)) begin
                        act     = ACT_TLB;
                        tlb_sel = code_hit;
                    end
                end
                default: act = ACT_TRAP;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_ctrl_map.sv
module sysctl_ctrl_map
    import sysctl_pkg::*;
(
    input  logic [DATA_W-1:0] ctrl,
    output logic              mmu_en,
    output logic              align_chk_en,
    output logic              dcache_en,
    output logic              icache_en,
    output logic              big_endian,
    output logic              sys_prot,
    output logic              rom_prot,
    output logic              rr_replace,
    output logic [DATA_W-1:0] vec_base,
    output logic [1:0]        clk_mode
);

    logic unused_bits;
    assign unused_bits = ^{ctrl[29:15], ctrl[11:10], ctrl[6:3]};

    assign mmu_en       = ctrl[0];
    assign align_chk_en = ctrl[1];
    assign dcache_en    = ctrl[2];
    assign big_endian   = ctrl[7];
    assign sys_prot     = ctrl[8];
    assign rom_prot     = ctrl[9];
    assign icache_en    = ctrl[12];
    assign rr_replace   = ctrl[14];
    assign vec_base     = ctrl[13] ? VEC_HIGH : '0;

    always_comb begin
        if (!ctrl[30])      clk_mode = 2'b00;
        else if (!ctrl[31]) clk_mode = 2'b01;
        else                clk_mode = 2'b10;
    end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xfer_valid,
    input  logic               xfer_write,
    input  logic               xfer_priv,
    input  logic [3:0]         xfer_crn,
    input  logic [3:0]         xfer_crm,
    input  logic [2:0]         xfer_op1,
    input  logic [2:0]         xfer_op2,
    input  logic [31:0]        xfer_wdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic               undef_trap,
    output logic [4:0]         tlb_cmd,
    output logic               cache_cmd,
    output logic [6:0]         cache_sel,
    output logic [31:0]        maint_addr,
    output logic               mmu_en,
    output logic               align_chk_en,
    output logic               dcache_en,
    output logic               icache_en,
    output logic               big_endian,
    output logic               sys_prot,
    output logic               rom_prot,
    output logic               rr_replace,
    output logic [31:0]        vec_base,
    output logic [1:0]         clk_mode
);

    bank_t              s_d, s_q;
    act_e               act;
    logic [TLB_OPS-1:0] tlb_sel;
    logic [GP_IW:0]     slot;
    logic [DATA_W-1:0]  rd_mux;

    sysctl_decode u_dec (
        .valid   (xfer_valid),
        .write   (xfer_write),
        .priv    (xfer_priv),
        .crn     (xfer_crn),
        .crm     (xfer_crm),
        .op1     (xfer_op1),
        .op2     (xfer_op2),
        .act     (act),
        .tlb_sel (tlb_sel)
    );

    assign slot = gp_slot(xfer_crn);

    always_comb begin
        case (xfer_crn)
            4'd0:    rd_mux = (xfer_op2 == 3'd1) ? cache_word() : ident_word();
            4'd1:    rd_mux = (s_q.ctrl & CTRL_WMASK) | CTRL_FIXED1;
            4'd2:    rd_mux = {s_q.ttb, {TTB_LSB{1'b0}}};
            4'd3:    rd_mux = s_q.dac;
            default: rd_mux = slot[GP_IW] ? s_q.gp[slot[GP_IW-1:0]] : '0;
        endcase
    end

    always_comb begin
        s_d           = s_q;
        s_d.rd_data   = '0;
        s_d.rd_valid  = 1'b0;
        s_d.trap      = 1'b0;
        s_d.tlb_cmd   = '0;
        s_d.cache_cmd = 1'b0;
        s_d.cache_sel = '0;
        case (act)
            ACT_TRAP: s_d.trap = 1'b1;
            ACT_READ: begin
                s_d.rd_valid = 1'b1;
                s_d.rd_data  = rd_mux;
            end
            ACT_WRITE: begin
                case (xfer_crn)
                    4'd1: s_d.ctrl = xfer_wdata & CTRL_WMASK;
                    4'd2: s_d.ttb  = xfer_wdata[DATA_W-1:TTB_LSB];
                    4'd3: s_d.dac  = xfer_wdata;
                    default: begin
                        if (slot[GP_IW]) s_d.gp[slot[GP_IW-1:0]] = xfer_wdata;
                    end
                endcase
            end
            ACT_TLB: begin
                s_d.tlb_cmd    = tlb_sel;
                s_d.maint_addr = xfer_wdata;
            end
            ACT_CACHE: begin
                s_d.cache_cmd  = 1'b1;
                s_d.cache_sel  = {xfer_crm, xfer_op2};
                s_d.maint_addr = xfer_wdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid   = s_q.rd_valid;
    assign rd_data    = s_q.rd_data;
    assign undef_trap = s_q.trap;
    assign tlb_cmd    = s_q.tlb_cmd;
    assign cache_cmd  = s_q.cache_cmd;
    assign cache_sel  = s_q.cache_sel;
    assign maint_addr = s_q.maint_addr;

    sysctl_ctrl_map u_map (
        .ctrl         (s_q.ctrl),
        .mmu_en       (mmu_en),
        .align_chk_en (align_chk_en),
        .dcache_en    (dcache_en),
        .icache_en    (icache_en),
        .big_endian   (big_endian),
        .sys_prot     (sys_prot),
        .rom_prot     (rom_prot),
        .rr_replace   (rr_replace),
        .vec_base     (vec_base),
        .clk_mode     (clk_mode)
    );

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_valid,
    input logic        xfer_write,
    input logic        xfer_priv,
    input logic [3:0]  xfer_crn,
    input logic [3:0]  xfer_crm,
    input logic [2:0]  xfer_op1,
    input logic [2:0]  xfer_op2,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        undef_trap,
    input logic [4:0]  tlb_cmd,
    input logic        cache_cmd,
    input logic        mmu_en,
    input logic        dcache_en,
    input logic        icache_en,
    input logic        big_endian,
    input logic [31:0] vec_base,
    input logic [1:0]  clk_mode
);

    AST_USER_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_priv |=> undef_trap); // R1

    AST_USER_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_priv |=> $stable(mmu_en) && $stable(dcache_en) && $stable(icache_en)
            && $stable(big_endian) && $stable(vec_base) && $stable(clk_mode)
            && (tlb_cmd == 5'd0) && !cache_cmd); // R1

    AST_OP1_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && (xfer_op1 != 3'd0) |=> undef_trap); // R2

    AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && xfer_priv && !xfer_write && (xfer_crn == 4'd1) && (xfer_crm == 4'd0)
            && (xfer_op1 == 3'd0) && (xfer_op2 == 3'd0)
        |=> rd_valid && (rd_data[6:3] == 4'hF) && (rd_data[11:10] == 2'b00)); // R4

    AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_base == 32'h0) || (vec_base == 32'hFFFF_0000)); // R5

    AST_CLK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_mode != 2'b11); // R6

    AST_TLB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tlb_cmd)); // R9

    AST_TRAP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        undef_trap |-> (rd_data == 32'h0) && !rd_valid && (tlb_cmd == 5'd0) && !cache_cmd); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_valid |=> !rd_valid && !undef_trap && (tlb_cmd == 5'd0) && !cache_cmd); // R12

endmodule

bind sysctl_regbank sysctl_regbank_chk u_chk (.*);

// File: tb/sysctl_regbank_test.sv
module sysctl_regbank_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_valid = 1'b0, xfer_write = 1'b0, xfer_priv = 1'b0;
    logic [3:0]  xfer_crn = '0, xfer_crm = '0;
    logic [2:0]  xfer_op1 = '0, xfer_op2 = '0;
    logic [31:0] xfer_wdata = '0;
    logic        rd_valid, undef_trap, cache_cmd;
    logic [31:0] rd_data, maint_addr, vec_base;
    logic [4:0]  tlb_cmd;
    logic [6:0]  cache_sel;
    logic        mmu_en, align_chk_en, dcache_en, icache_en, big_endian;
    logic        sys_prot, rom_prot, rr_replace;
    logic [1:0]  clk_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_ctrl, m_dac;
    logic [17:0] m_ttb;
    logic [31:0] m_gp [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_regbank uut (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_read();
        return (m_ctrl & 32'hC000_7387) | 32'h78;
    endfunction

    function automatic bit is_gp(input logic [3:0] crn);
        return crn inside {4'd5, 4'd6, 4'd9, 4'd10, 4'd13, 4'd15};
    endfunction

    task automatic check_ctrl();
        logic [1:0] em;
        chk("R5", "mmu_en", {31'd0, mmu_en}, {31'd0, m_ctrl[0]});
        chk("R5", "flags", {24'd0, align_chk_en, dcache_en, icache_en, big_endian,
                            sys_prot, rom_prot, rr_replace, 1'b0},
            {24'd0, m_ctrl[1], m_ctrl[2], m_ctrl[12], m_ctrl[7], m_ctrl[8], m_ctrl[9], m_ctrl[14], 1'b0});
        chk("R5", "vec_base", vec_base, m_ctrl[13] ? 32'hFFFF_0000 : 32'h0);
        em = !m_ctrl[30] ? 2'b00 : (!m_ctrl[31] ? 2'b01 : 2'b10);
        chk("R6", "clk_mode", {30'd0, clk_mode}, {30'd0, em});
    endtask

    task automatic xfer(input bit w, input bit p, input logic [3:0] crn, input logic [3:0] crm,
                        input logic [2:0] op1, input logic [2:0] op2, input logic [31:0] wd);
        bit          e_trap = 1'b1, e_rv = 1'b0, e_cc = 1'b0;
        logic [31:0] e_rd = '0;
        logic [4:0]  e_tlb = '0;
        string       tag;
        bit          plain = (crm == 4'd0) && (op2 == 3'd0);
        if (!p) tag = "R1";
        else if (op1 != 3'd0) tag = "R2";
        else if (crn == 4'd0) tag = "R3";
        else if (crn == 4'd1) tag = "R4";
        else if (crn == 4'd2 || crn == 4'd3) tag = "R7";
        else if (is_gp(crn)) tag = "R8";
        else if (crn == 4'd8) tag = "R9";
        else if (crn == 4'd7) tag = "R10";
        else tag = "R11";
        if (p && op1 == 3'd0) begin
            if (crn == 4'd0) begin
                if (!w && crm == 4'd0) begin
                    e_trap = 0; e_rv = 1;
                    e_rd = (op2 == 3'd1) ? 32'h0D17_2172 : 32'h4112_9200;
                end
            end else if (crn inside {4'd1, 4'd2, 4'd3} || is_gp(crn)) begin
                if (plain) begin
                    e_trap = 0;
                    if (w) begin
                        if (crn == 4'd1) m_ctrl = wd & 32'hC000_7387;
                        else if (crn == 4'd2) m_ttb = wd[31:14];
                        else if (crn == 4'd3) m_dac = wd;
                        else m_gp[crn] = wd;
                    end else begin
                        e_rv = 1;
                        if (crn == 4'd1) e_rd = ctrl_read();
                        else if (crn == 4'd2) e_rd = {m_ttb, 14'd0};
                        else if (crn == 4'd3) e_rd = m_dac;
                        else e_rd = m_gp[crn];
                    end
                end
            end else if (crn == 4'd7 && w) begin
                e_trap = 0; e_cc = 1;
            end else if (crn == 4'd8 && w) begin
                case ({crm, op2})
                    7'h38: e_tlb = 5'b00001;
                    7'h28: e_tlb = 5'b00010;
                    7'h29: e_tlb = 5'b00100;
                    7'h30: e_tlb = 5'b01000;
                    7'h31: e_tlb = 5'b10000;
                    default: e_tlb = 5'b0;
                endcase
                e_trap = (e_tlb == 5'b0);
            end
        end
        @(negedge clk);
        xfer_valid = 1; xfer_write = w; xfer_priv = p; xfer_crn = crn;
        xfer_crm = crm; xfer_op1 = op1; xfer_op2 = op2; xfer_wdata = wd;
        @(negedge clk);
        xfer_valid = 0;
        chk(tag, "undef_trap", {31'd0, undef_trap}, {31'd0, e_trap});
        chk(tag, "rd_valid", {31'd0, rd_valid}, {31'd0, e_rv});
        chk(tag, "rd_data", rd_data, e_rd);
        chk(tag, "tlb_cmd", {27'd0, tlb_cmd}, {27'd0, e_tlb});
        chk(tag, "cache_cmd", {31'd0, cache_cmd}, {31'd0, e_cc});
        if (e_tlb != 5'b0 || e_cc) chk(tag, "maint_addr", maint_addr, wd);
        if (e_cc) chk("R10", "cache_sel", {25'd0, cache_sel}, {25'd0, crm, op2});
        check_ctrl();
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        chk(req, "idle pulses", {24'd0, rd_valid, undef_trap, cache_cmd, tlb_cmd},  32'd0);
    endtask

    initial begin
        m_ctrl = '0; m_dac = '0; m_ttb = '0;
        foreach (m_gp[i]) m_gp[i] = '0;
        void'($urandom(32'h0005_EED1));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R12", "reset pulses", {24'd0, rd_valid, undef_trap, cache_cmd, tlb_cmd}, 32'd0);
        check_ctrl();
        xfer(0, 1, 4'd1, 0, 0, 0, 0);                 // R4 reset readback 0x78
        xfer(0, 1, 4'd13, 0, 0, 0, 0);                // R8 reset zero
        // R3 all op2 on register 0
        for (int k = 0; k < 8; k++) xfer(0, 1, 4'd0, 0, 0, 3'(k), 0);
        xfer(1, 1, 4'd0, 0, 0, 0, 32'h1234);          // R3 write traps
        xfer(0, 1, 4'd0, 4'd2, 0, 1, 0);              // R3 crm nonzero traps
        // R4 R5 R6 control register
        xfer(1, 1, 4'd1, 0, 0, 0, 32'hFFFF_FFFF);
        xfer(0, 1, 4'd1, 0, 0, 0, 0);
        xfer(1, 1, 4'd1, 0, 0, 0, 32'h4000_0000);     // R6 synchronous
        xfer(1, 1, 4'd1, 0, 0, 0, 32'h0000_0000);
        xfer(0, 1, 4'd1, 0, 0, 0, 0);
        // R1 user mode write ignored
        xfer(1, 0, 4'd1, 0, 0, 0, 32'hFFFF_FFFF);
        xfer(0, 1, 4'd1, 0, 0, 0, 0);
        xfer(1, 0, 4'd8, 4'd7, 0, 0, 32'h55);
        // R2 field checks
        xfer(0, 1, 4'd1, 0, 3'd1, 0, 0);
        xfer(1, 1, 4'd3, 4'd1, 0, 0, 32'hA5A5);
        xfer(0, 1, 4'd3, 0, 0, 0, 0);
        xfer(1, 1, 4'd2, 0, 0, 3'd2, 32'hFFFF);
        // R7
        xfer(1, 1, 4'd2, 0, 0, 0, 32'hFFFF_FFFF);
        xfer(0, 1, 4'd2, 0, 0, 0, 0);
        xfer(1, 1, 4'd3, 0, 0, 0, 32'hDEAD_BEEF);
        xfer(0, 1, 4'd3, 0, 0, 0, 0);
        // R9 every TLB code, then near misses; R12 pulse lasts one cycle
        xfer(1, 1, 4'd8, 4'd7, 0, 0, 32'h1000); idle_check("R12");
        xfer(1, 1, 4'd8, 4'd5, 0, 0, 32'h2000); idle_check("R12");
        xfer(1, 1, 4'd8, 4'd5, 0, 1, 32'h3000); idle_check("R12");
        xfer(1, 1, 4'd8, 4'd6, 0, 0, 32'h4000); idle_check("R12");
        xfer(1, 1, 4'd8, 4'd6, 0, 1, 32'h5000); idle_check("R12");
        xfer(1, 1, 4'd8, 4'd7, 0, 1, 32'h6000);
        xfer(1, 1, 4'd8, 4'd4, 0, 0, 32'h7000);
        xfer(0, 1, 4'd8, 4'd7, 0, 0, 0);
        // R10
        xfer(1, 1, 4'd7, 4'd10, 0, 3'd4, 32'hCAFE_0040); idle_check("R10");
        xfer(0, 1, 4'd7, 4'd10, 0, 3'd4, 0);
        // R11 reserved registers
        xfer(0, 1, 4'd4, 0, 0, 0, 0);
        xfer(1, 1, 4'd11, 0, 0, 0, 32'h1);
        xfer(0, 1, 4'd14, 0, 0, 0, 0);
        // constrained random
        for (int n = 0; n < 1500; n++) begin
            logic [3:0]  crn = 4'($urandom_range(0, 15));
            logic [3:0]  crm = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
            logic [2:0]  op2 = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'd0;
            logic [2:0]  op1 = ($urandom_range(0, 15) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
            bit          p   = ($urandom_range(0, 7) != 0);
            bit          w   = 1'($urandom_range(0, 1));
            if (crn == 4'd8 && $urandom_range(0, 1) == 1) begin
                crm = 4'($urandom_range(5, 7));
                op2 = 3'($urandom_range(0, 1));
            end
            xfer(w, p, crn, crm, op1, op2, $urandom());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule